// File: doc/BRIEF.md
# Clear-on-read interrupt status aggregator

This block gathers event pulses from many sources in a multi-port line controller and holds them as four sticky summary bits in one 16-bit status register. Any receive port's frame-alignment change sets one bit and any transmit port's sets another. Five kinds of tester indication share a third bit. A bus system error sets the fourth. Pulses from several ports in one cycle set their summary bit once.

A host reads the status register with a single-cycle read strobe. The read returns the current bits and clears them. A companion mask register, readable and writable at its own offset, selects which status bits may raise interrupts. Two active-low interrupt outputs are driven from registers. The host-bus interrupt follows any enabled, set status bit. The local-bus interrupt does the same, but only while the configuration-mode input is high.

Top module: `intr_status_agg`

## Requirements
- R1: After a synchronous reset the status bits and the mask bits are 0, both interrupt outputs are 1, and a read of either register returns 0.
- R2: A pulse on any one or more bits of the receive alignment event input sets status bit 0.
- R3: A pulse on any one or more bits of the transmit alignment event input sets status bit 1.
- R4: A pulse on any of the five tester inputs sets status bit 2. The tester inputs are, by bit index: 0 sync gained, 1 sync lost, 2 bit error, 3 bit-counter overflow, 4 error-counter overflow.
- R5: A pulse on the system-error input sets status bit 3.
- R6: A read strobe at offset 0x20 returns the status bits on the read data port in the following cycle and clears all status bits. In any cycle without a read, the read data port is 0.
- R7: An event in the same cycle as a status read is not lost. The read returns the bit's old value, and the bit is 1 afterwards.
- R8: A set status bit stays set until a status read. Reads of other offsets do not clear it, and writes have no effect on it.
- R9: The mask register at offset 0x24 stores write data bits 3:0 and reads them back in the same bit positions.
- R10: The host interrupt output is 0 one cycle after status AND mask is nonzero, and 1 one cycle after it is zero.
- R11: The local interrupt output is 0 one cycle after status AND mask is nonzero while the configuration-mode input is 1. Otherwise it is 1.
- R12: Read data bits 15:4 are always 0, and a read of any offset other than 0x20 or 0x24 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_align_evt | input | N_RX | Receive-port frame-alignment change pulses |
| tx_align_evt | input | N_TX | Transmit-port frame-alignment change pulses |
| tst_evt | input | 5 | Tester state-change pulses |
| sys_err | input | 1 | Bus system-error pulse |
| cfg_mode | input | 1 | Local bus in configuration mode |
| reg_rd | input | 1 | Register read strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register offset |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data, valid one cycle after the strobe |
| host_irq_n | output | 1 | Active-low host-bus interrupt |
| local_irq_n | output | 1 | Active-low local-bus interrupt |

## Verification
The bench builds the block with eight receive ports and six transmit ports. The unequal widths show that the two summary reductions are sized independently. Multi-bit pulses across the top and bottom port indexes reach the case where several ports fire in one cycle. The 16-bit data width leaves twelve upper bits to prove they read as zero. Writing all-ones-above-the-field mask data shows that only the low four bits are stored.

// File: rtl/isa_pkg.sv
package isa_pkg;
  localparam int STAT_W  = 4;
  localparam int TST_W   = 5;
  localparam int B_RXALN = 0;
  localparam int B_TXALN = 1;
  localparam int B_TST   = 2;
  localparam int B_SYS   = 3;
endpackage

// File: rtl/isa_evt_merge.sv
module isa_evt_merge
  import isa_pkg::*;
#(
  parameter int N_RX = 8,
  parameter int N_TX = 8
) (
  input  logic [N_RX-1:0]   rx_evt,
  input  logic [N_TX-1:0]   tx_evt,
  input  logic [TST_W-1:0]  tst_evt,
  input  logic              sys_err,
  output logic [STAT_W-1:0] evt
);
  always_comb begin
    evt          = '0;
    evt[B_RXALN] = |rx_evt;
    evt[B_TXALN] = |tx_evt;
    evt[B_TST]   = |tst_evt;
    evt[B_SYS]   = sys_err;
  end
endmodule

// File: rtl/isa_sticky.sv
module isa_sticky #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set,
  input  logic         clr,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst) q[i] <= 1'b0;
      else     q[i] <= set[i] | (q[i] & ~clr);
    end
  end
endmodule

// File: rtl/isa_irq_out.sv
module isa_irq_out #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] status,
  input  logic [W-1:0] mask,
  input  logic         cfg_mode,
  output logic         host_irq_n,
  output logic         local_irq_n
);
  logic pend;
  assign pend = |(status & mask);

  always_ff @(posedge clk) begin
    if (rst) begin
      host_irq_n  <= 1'b1;
      local_irq_n <= 1'b1;
    end else begin
      host_irq_n  <= ~pend;
      local_irq_n <= ~(pend & cfg_mode);
    end
  end
endmodule

// File: rtl/intr_status_agg.sv
module intr_status_agg
  import isa_pkg::*;
#(
  parameter int                N_RX      = 8,
  parameter int                N_TX      = 8,
  parameter int                ADDR_W    = 8,
  parameter int                DATA_W    = 16,
  parameter logic [ADDR_W-1:0] STAT_OFFS = 'h20,
  parameter logic [ADDR_W-1:0] MASK_OFFS = 'h24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_RX-1:0]   rx_align_evt,
  input  logic [N_TX-1:0]   tx_align_evt,
  input  logic [TST_W-1:0]  tst_evt,
  input  logic              sys_err,
  input  logic              cfg_mode,
  input  logic              reg_rd,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              host_irq_n,
  output logic              local_irq_n
);
  localparam int PAD_W = DATA_W - STAT_W;

  logic [STAT_W-1:0] evt;
  logic [STAT_W-1:0] status_q;
  logic [STAT_W-1:0] mask_q;
  logic              rd_stat;
  logic              rd_mask;
  logic              wr_mask;
  logic              unused_wdata_hi;

  assign rd_stat         = reg_rd && (reg_addr == STAT_OFFS);
  assign rd_mask         = reg_rd && (reg_addr == MASK_OFFS);
  assign wr_mask         = reg_wr && (reg_addr == MASK_OFFS);
  assign unused_wdata_hi = ^reg_wdata[DATA_W-1:STAT_W];

  isa_evt_merge #(.N_RX(N_RX), .N_TX(N_TX)) u_merge (
    .rx_evt  (rx_align_evt),
    .tx_evt  (tx_align_evt),
    .tst_evt (tst_evt),
    .sys_err (sys_err),
    .evt     (evt)
  );

  isa_sticky #(.W(STAT_W)) u_status (
    .clk (clk),
    .rst (rst),
    .set (evt),
    .clr (rd_stat),
    .q   (status_q)
  );

  always_ff @(posedge clk) begin
    if (rst)          mask_q <= '0;
    else if (wr_mask) mask_q <= reg_wdata[STAT_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst)          reg_rdata <= '0;
    else if (rd_stat) reg_rdata <= {{PAD_W{1'b0}}, status_q};
    else if (rd_mask) reg_rdata <= {{PAD_W{1'b0}}, mask_q};
    else              reg_rdata <= '0;
  end

  isa_irq_out #(.W(STAT_W)) u_irq (
    .clk         (clk),
    .rst         (rst),
    .status      (status_q),
    .mask        (mask_q),
    .cfg_mode    (cfg_mode),
    .host_irq_n  (host_irq_n),
    .local_irq_n (local_irq_n)
  );
endmodule

// File: rtl/intr_status_agg_chk.sv
module intr_status_agg_chk
  import isa_pkg::*;
#(
  parameter int                N_RX      = 8,
  parameter int                N_TX      = 8,
  parameter int                ADDR_W    = 8,
  parameter int                DATA_W    = 16,
  parameter logic [ADDR_W-1:0] STAT_OFFS = 'h20
) (
  input logic              clk,
  input logic              rst,
  input logic [N_RX-1:0]   rx_align_evt,
  input logic [N_TX-1:0]   tx_align_evt,
  input logic [TST_W-1:0]  tst_evt,
  input logic              sys_err,
  input logic              cfg_mode,
  input logic              reg_rd,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [STAT_W-1:0] status_q,
  input logic [STAT_W-1:0] mask_q,
  input logic [DATA_W-1:0] reg_rdata,
  input logic              host_irq_n,
  input logic              local_irq_n
);
  logic rd_s;
  assign rd_s = reg_rd && (reg_addr == STAT_OFFS);

  AST_RESET_STATE: assert property (@(posedge clk)
    rst |=> (status_q == '0 && mask_q == '0 && host_irq_n && local_irq_n)); // R1
  AST_RX_SETS: assert property (@(posedge clk) disable iff (rst)
    (|rx_align_evt) |=> status_q[B_RXALN]); // R2
  AST_TX_SETS: assert property (@(posedge clk) disable iff (rst)
    (|tx_align_evt) |=> status_q[B_TXALN]); // R3
  AST_TST_SETS: assert property (@(posedge clk) disable iff (rst)
    (|tst_evt) |=> status_q[B_TST]); // R4
  AST_SYS_SETS: assert property (@(posedge clk) disable iff (rst)
    sys_err |=> status_q[B_SYS]); // R5
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (rd_s && !sys_err) |=> !status_q[B_SYS]); // R6
  AST_READ_RETURNS: assert property (@(posedge clk) disable iff (rst)
    rd_s |=> (reg_rdata[STAT_W-1:0] == $past(status_q))); // R7
  AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (rst)
    (status_q[B_RXALN] && !rd_s) |=> status_q[B_RXALN]); // R8
  AST_HOST_IRQ: assert property (@(posedge clk) disable iff (rst)
    (|(status_q & mask_q)) |=> !host_irq_n); // R10
  AST_HOST_QUIET: assert property (@(posedge clk) disable iff (rst)
    !(|(status_q & mask_q)) |=> host_irq_n); // R10
  AST_LOCAL_GATED: assert property (@(posedge clk) disable iff (rst)
    !cfg_mode |=> local_irq_n); // R11
  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    reg_rdata[DATA_W-1:STAT_W] == '0); // R12
endmodule

bind intr_status_agg intr_status_agg_chk #(
  .N_RX(N_RX), .N_TX(N_TX), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .STAT_OFFS(STAT_OFFS)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .rx_align_evt (rx_align_evt),
  .tx_align_evt (tx_align_evt),
  .tst_evt      (tst_evt),
  .sys_err      (sys_err),
  .cfg_mode     (cfg_mode),
  .reg_rd       (reg_rd),
  .reg_addr     (reg_addr),
  .status_q     (status_q),
  .mask_q       (mask_q),
  .reg_rdata    (reg_rdata),
  .host_irq_n   (host_irq_n),
  .local_irq_n  (local_irq_n)
);

// File: tb/intr_status_agg_tb.sv
`timescale 1ns/1ps
module intr_status_agg_tb;
  localparam int N_RX = 8;
  localparam int N_TX = 6;
  localparam int NV   = 20;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [N_RX-1:0] rx_align_evt = '0;
  logic [N_TX-1:0] tx_align_evt = '0;
  logic [4:0]  tst_evt = '0;
  logic        sys_err = 1'b0, cfg_mode = 1'b0, reg_rd = 1'b0, reg_wr = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        host_irq_n, local_irq_n;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  intr_status_agg #(.N_RX(N_RX), .N_TX(N_TX)) u_dut (
    .clk(clk), .rst(rst), .rx_align_evt(rx_align_evt), .tx_align_evt(tx_align_evt),
    .tst_evt(tst_evt), .sys_err(sys_err), .cfg_mode(cfg_mode), .reg_rd(reg_rd),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .host_irq_n(host_irq_n), .local_irq_n(local_irq_n)
  );

  // rx(8) tx(8) tst(5) serr cfg rd wr addr(8) wdata(16) | exp rdata(16) host_n local_n
  localparam logic [66:0] VEC [0:NV-1] = '{
    {8'h01,8'h00,5'h00,1'b0,1'b0,1'b0,1'b0,8'h00,16'h0000, 16'h0000,1'b1,1'b1}, // R2 masked
    {8'h00,8'h00,5'h00,1'b0,1'b0,1'b0,1'b1,8'h24,16'h000F, 16'h0000,1'b0,1'b1}, // R9 R10
    {8'h00,8'h00,5'h00,1'b0,1'b0,1'b1,1'b0,8'h24,16'h0000, 16'h000F,1'b0,1'b1}, // R9
    {8'h00,8'h00,5'h00,1'b0,1'b1,1'b0,1'b0,8'h00,16'h0000, 16'h0000,1'b0,1'b0}, // R11
    {8'h00,8'h00,5'h00,1'b0,1'b1,1'b1,1'b0,8'h20,16'h0000, 16'h0001,1'b1,1'b1}, // R6
    {8'hFF,8'h21,5'h00,1'b0,1'b1,1'b0,1'b0,8'h00,16'h0000, 16'h0000,1'b0,1'b0}, // R2 R3
    {8'h00,8'h00,5'h00,1'b1,1'b1,1'b1,1'b0,8'h20,16'h0000, 16'h0003,1'b0,1'b0}, // R5 R7
    {8'h00,8'h00,5'h00,1'b0,1'b1,1'b1,1'b0,8'h20,16'h0000, 16'h0008,1'b1,1'b1}, // R6
    {8'h00,8'h00,5'h04,1'b0,1'b0,1'b0,1'b0,8'h00,16'h0000, 16'h0000,1'b0,1'b1}, // R4 R11
    {8'h00,8'h00,5'h00,1'b0,1'b0,1'b1,1'b0,8'h30,16'h0000, 16'h0000,1'b0,1'b1}, // R8 R12
    {8'h00,8'h00,5'h00,1'b0,1'b0,1'b0,1'b1,8'h24,16'hFFF3, 16'h0000,1'b1,1'b1}, // R9 R10
    {8'h00,8'h00,5'h00,1'b0,1'b0,1'b1,1'b0,8'h24,16'h0000, 16'h0003,1'b1,1'b1}, // R12
    {8'h00,8'h00,5'h10,1'b0,1'b0,1'b1,1'b0,8'h20,16'h0000, 16'h0004,1'b1,1'b1}, // R7
    {8'h00,8'h00,5'h01,1'b0,1'b1,1'b0,1'b1,8'h20,16'hFFFF, 16'h0000,1'b1,1'b1}, // R4 R8
    {8'h00,8'h00,5'h00,1'b0,1'b1,1'b0,1'b1,8'h24,16'h0004, 16'h0000,1'b0,1'b0}, // R10 R11
    {8'h00,8'h00,5'h00,1'b0,1'b1,1'b1,1'b0,8'h20,16'h0000, 16'h0004,1'b1,1'b1}, // R6
    {8'h00,8'h00,5'h08,1'b0,1'b1,1'b0,1'b0,8'h00,16'h0000, 16'h0000,1'b0,1'b0}, // R4
    {8'h00,8'h00,5'h00,1'b0,1'b1,1'b1,1'b0,8'h20,16'h0000, 16'h0004,1'b1,1'b1}, // R6
    {8'h00,8'h00,5'h02,1'b0,1'b1,1'b0,1'b0,8'h00,16'h0000, 16'h0000,1'b0,1'b0}, // R4
    {8'h00,8'h00,5'h00,1'b0,1'b1,1'b1,1'b0,8'h20,16'h0000, 16'h0004,1'b1,1'b1}  // R6
  };

  task automatic chk(input string tag, input int idx, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s step %0d: actual %h expected %h", tag, idx, act, exp);
    end
  endtask

  task automatic idle();
    rx_align_evt = '0; tx_align_evt = '0; tst_evt = '0; sys_err = 0;
    reg_rd = 0; reg_wr = 0; reg_addr = '0; reg_wdata = '0;
  endtask

  task automatic rd_reg(input logic [7:0] a);
    reg_rd = 1; reg_addr = a;
    @(negedge clk); idle();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #200000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    chk("R1 rdata", -1, reg_rdata, 16'h0);
    chk("R1 host_irq_n", -1, {15'h0, host_irq_n}, 16'h1);
    chk("R1 local_irq_n", -1, {15'h0, local_irq_n}, 16'h1);

    for (int i = 0; i < NV; i++) begin
      logic [66:0] v;
      v = VEC[i];
      rx_align_evt = v[66:59];
      tx_align_evt = v[N_TX+50:51];
      tst_evt = v[50:46]; sys_err = v[45]; cfg_mode = v[44];
      reg_rd = v[43]; reg_wr = v[42]; reg_addr = v[41:34]; reg_wdata = v[33:18];
      @(negedge clk);
      chk("R6/R9/R12 rdata", i, reg_rdata, v[17:2]);
      idle();
      @(negedge clk);
      chk("R10 host_irq_n", i, {15'h0, host_irq_n}, {15'h0, v[1]});
      chk("R11 local_irq_n", i, {15'h0, local_irq_n}, {15'h0, v[0]});
    end

    // R1: reset in mid-run with a status bit set and the mask loaded
    cfg_mode = 1; rx_align_evt = 8'h80; reg_wr = 1; reg_addr = 8'h24; reg_wdata = 16'h000F;
    @(negedge clk); idle();
    @(negedge clk);
    chk("R1 pre host_irq_n", 100, {15'h0, host_irq_n}, 16'h0);
    rst = 1;
    repeat (2) @(negedge clk);
    rst = 0;
    chk("R1 host_irq_n", 101, {15'h0, host_irq_n}, 16'h1);
    chk("R1 local_irq_n", 102, {15'h0, local_irq_n}, 16'h1);
    rd_reg(8'h20);
    chk("R1 status", 103, reg_rdata, 16'h0);
    rd_reg(8'h24);
    chk("R1 mask", 104, reg_rdata, 16'h0);
    // R6: no strobe -> read data returns to 0
    @(negedge clk);
    chk("R6 idle rdata", 105, reg_rdata, 16'h0);
    finish_run();
  end
endmodule